// File: doc/BRIEF.md
# Triggered Front-End Channel with Derandomizer

The block models one synchronizer channel of a triggered readout chain. On every bunch-crossing clock it stores the incoming TDC measurement, together with the current bunch-crossing number, in a fixed-latency circular pipeline buffer. When a level-0 accept arrives, the entry written exactly `LATENCY` crossings earlier is copied into a derandomizer FIFO. The copy is tagged with an event number.

A downstream controller drains the derandomizer through a 32-bit port. Each event takes two accesses. The first access returns the data word, which carries the TDC value. The second access returns the info word, which carries the crossing number, the event number and two error bits. The event is popped on the second access.

Both storage stages hold SEC-DED protected codewords. A single-bit error is repaired and reported by a one-cycle pulse. A double-bit error sets a sticky flag, and that flag also appears in the info word. Two fault-injection masks are provided so that the protection can be exercised: one is XORed into each codeword as it is written into the pipeline buffer, and the other is XORed into each codeword as it is written into the derandomizer.

Top module: `trig_fe_channel`

## Requirements
- R1: After reset, `rd_valid`, `rd_info`, `sec_fix`, `ded_err` and `ovf_err` are all 0.
- R2: The crossing counter starts at 0 on the first clock edge after reset and advances by one per clock. It wraps from `BX_WRAP-1` (default 3563) to 0. The value captured with an entry appears in bits [11:0] of the info word.
- R3: An accept sampled on clock edge n stores the entry captured on edge n-`LATENCY`. The data word of that event equals the `tdc_in` value sampled on that earlier edge.
- R4: The event counter starts at 0 and increments on every accept, including accepts that are dropped. Bits [23:12] of the info word hold the counter value at the event's accept.
- R5: While `rd_valid` is 1, the first `rd_en` access presents the data word with `rd_info`=0. The next access presents the info word with `rd_info`=1. The event is removed on the clock edge that ends the info access, and the events come out in accept order.
- R6: `rd_en` while the derandomizer is empty has no effect: `rd_valid` stays 0 and the next stored event still starts with its data word.
- R7: The derandomizer holds `DEPTH` events (default 16). An accept that arrives while it is full is dropped, and it sets the sticky `ovf_err`, which is shown in info bit 30.
- R8: A single flipped bit in a pipeline-buffer codeword is corrected when the entry is accepted, and `sec_fix` pulses for one cycle after that accept edge.
- R9: A single flipped bit in a derandomizer codeword is corrected on each read access, and `sec_fix` pulses for one cycle after each such access.
- R10: A double flipped bit sets the sticky `ded_err`. For the pipeline buffer this happens at the accept; for the derandomizer it happens at a read access. Info bit 31 shows `ded_err`, ORed with the double-error status of the event being read. Info bits [29:24] are 0.
- R11: An accept within the first `LATENCY` edges after reset delivers data word 0 and crossing number 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdc_in | input | 32 | TDC measurement, captured every clock |
| l0_acc | input | 1 | Level-0 accept |
| buf_flip | input | 64 | Fault mask XORed into the pipeline-buffer codeword being written |
| fifo_flip | input | 64 | Fault mask XORed into the derandomizer codeword being written |
| rd_en | input | 1 | Read access strobe |
| rd_valid | output | 1 | Derandomizer holds at least one event |
| rd_word | output | 32 | Current word: data or info |
| rd_info | output | 1 | 1 when `rd_word` is the info word |
| sec_fix | output | 1 | One-cycle pulse after a single-bit correction |
| ded_err | output | 1 | Sticky double-bit error flag |
| ovf_err | output | 1 | Sticky derandomizer overflow flag |

## Verification
The bench goes after the latency alignment. It fires accepts before the buffer has filled, and it fires accepts whose source entries sit on either side of the crossing-counter wrap. An off-by-one pointer would return the neighbouring crossing's TDC value, and a wrong wrap would show crossing number 3564.

It fills the derandomizer while reads are held off, to show that excess accepts are dropped while the event numbers keep counting. A design that overwrote entries or stalled the event counter would return the wrong data or event IDs.

Single and double faults are injected into each stage. A decoder that did not correct, or that pulsed only once per event, would miscompare the data or the `sec_fix` pattern. A decoder that misclassified a double fault would leave bit 31 clear.

// File: rtl/trig_fe_channel.sv
module trig_fe_channel #(
  parameter int LATENCY = 160,
  parameter int DEPTH   = 16,
  parameter int BX_WRAP = 3564
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tdc_in,
  input  logic        l0_acc,
  input  logic [63:0] buf_flip,
  input  logic [63:0] fifo_flip,
  input  logic        rd_en,
  output logic        rd_valid,
  output logic [31:0] rd_word,
  output logic        rd_info,
  output logic        sec_fix,
  output logic        ded_err,
  output logic        ovf_err
);
  localparam int PW  = $clog2(LATENCY);
  localparam int FW  = $clog2(DEPTH);
  localparam int CNT = 12;
  localparam int KW  = 56;
  localparam int CW  = 64;

  function automatic logic [CW-1:0] sd_enc(input logic [KW-1:0] d);
    logic [CW-1:0] c;
    logic p;
    int k;
    c = '0;
    k = 0;
    for (int j = 1; j < CW; j++)
      if ((j & (j - 1)) != 0 && k < KW) begin
        c[j] = d[k];
        k++;
      end
    for (int i = 0; i < 6; i++) begin
      p = 1'b0;
      for (int j = 1; j < CW; j++)
        if (((j >> i) & 1) == 1 && (j & (j - 1)) != 0) p = p ^ c[j];
      c[1 << i] = p;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  // result: {double, odd_parity (corrected), payload}
  function automatic logic [KW+1:0] sd_dec(input logic [CW-1:0] cw);
    logic [CW-1:0] c;
    logic [5:0] syn;
    logic par;
    logic [KW-1:0] d;
    int k;
    c = cw;
    syn = '0;
    for (int j = 1; j < CW; j++)
      if (c[j]) syn = syn ^ 6'(j);
    par = ^c;
    if (par && syn != 6'd0) c[syn] = ~c[syn];
    d = '0;
    k = 0;
    for (int j = 1; j < CW; j++)
      if ((j & (j - 1)) != 0 && k < KW) begin
        d[k] = c[j];
        k++;
      end
    return {(!par && syn != 6'd0), par, d};
  endfunction

  logic [CNT-1:0] bx, ev;
  logic [PW-1:0]  bp;
  logic [CW-1:0]  pbuf [LATENCY];
  logic [CW-1:0]  dbuf [DEPTH];
  logic [FW-1:0]  wp, rp;
  logic [FW:0]    cnt;
  logic           phase;

  wire [KW+1:0] bdec    = sd_dec(pbuf[bp]);
  wire [KW+1:0] fdec    = sd_dec(dbuf[rp]);
  wire          full    = cnt == (FW+1)'(DEPTH);
  wire          rd_fire = rd_en && cnt != '0;
  wire          pop     = rd_fire && phase;
  wire          acc_st  = l0_acc && !full;
  wire [CW-1:0] fcw     = sd_enc({ev, bdec[43:0]}) ^ fifo_flip;

  assign rd_valid = cnt != '0;
  assign rd_info  = phase;
  assign rd_word  = phase ? {ded_err | fdec[KW+1], ovf_err, 6'd0, fdec[55:32]}
                          : fdec[31:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bx <= '0;
      ev <= '0;
      bp <= '0;
      for (int i = 0; i < LATENCY; i++) pbuf[i] <= '0;
    end else begin
      bx <= (bx == CNT'(BX_WRAP - 1)) ? '0 : bx + 1'b1;
      bp <= (bp == PW'(LATENCY - 1)) ? '0 : bp + 1'b1;
      pbuf[bp] <= sd_enc({12'd0, bx, tdc_in}) ^ buf_flip;
      if (l0_acc) ev <= ev + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      phase <= 1'b0;
      sec_fix <= 1'b0;
      ded_err <= 1'b0;
      ovf_err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) dbuf[i] <= '0;
    end else begin
      if (acc_st) begin
        dbuf[wp] <= fcw;
        wp <= (wp == FW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (rd_fire) phase <= ~phase;
      if (pop) rp <= (rp == FW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (FW+1)'(acc_st) - (FW+1)'(pop);
      sec_fix <= (acc_st && bdec[KW]) || (rd_fire && fdec[KW]);
      if ((acc_st && bdec[KW+1]) || (rd_fire && fdec[KW+1])) ded_err <= 1'b1;
      if (l0_acc && full) ovf_err <= 1'b1;
    end

  p_bx_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bx == CNT'(BX_WRAP - 1) |=> bx == '0);
  p_ev_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    l0_acc |=> ev == CNT'($past(ev) + 1'b1));
  p_phase_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_valid && rd_info |=> !rd_info);
  p_empty_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && rd_en && !l0_acc |=> !rd_valid && !rd_info);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (FW+1)'(DEPTH));
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l0_acc && full && !(rd_en && rd_info) |=> cnt == $past(cnt) && ovf_err);
  p_ded_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ded_err |=> ded_err);
endmodule

// File: tb/sim_trig_fe_channel.sv
module sim_trig_fe_channel;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 160;
  localparam int DEP = 16;
  localparam int WRAP = 3564;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tdc_in = '0;
  logic l0_acc = 1'b0, rd_en = 1'b0;
  logic [63:0] buf_flip = '0, fifo_flip = '0;
  logic rd_valid, rd_info, sec_fix, ded_err, ovf_err;
  logic [31:0] rd_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_fe_channel u0 (.clk, .rst_n, .tdc_in, .l0_acc, .buf_flip, .fifo_flip,
    .rd_en, .rd_valid, .rd_word, .rd_info, .sec_fix, .ded_err, .ovf_err);

  typedef struct {
    logic [31:0] tdc; int bx; int ev; int fw; bit skip; bit early;
  } evt_t;

  evt_t q[$];
  logic [31:0] h_tdc[$];
  int h_w[$];
  int cyc = 0, evn = 0, vec = 0, miss = 0;
  bit m_phase = 0, m_sec = 0, m_ded = 0, m_ovf = 0, sec_buf = 0, tried_empty = 0;

  function automatic logic [31:0] tdc_of(int c);
    return (32'(c) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  task automatic compare();
    check(tried_empty ? "R6 valid" : "R5 valid", 32'(rd_valid), 32'(q.size() > 0));
    check("R5 phase", 32'(rd_info), 32'(m_phase));
    check(sec_buf ? "R8 sec_fix" : "R9 sec_fix", 32'(sec_fix), 32'(m_sec));
    check("R10 ded_err", 32'(ded_err), 32'(m_ded));
    check("R7 ovf_err", 32'(ovf_err), 32'(m_ovf));
    if (q.size() > 0) begin
      if (!m_phase) begin
        if (!q[0].skip && q[0].fw != 2)
          check(q[0].early ? "R11 data" : "R3 data", rd_word, q[0].tdc);
      end else begin
        check("R10 info err", 32'(rd_word[31]), 32'(m_ded || q[0].fw == 2));
        check("R7 info ovf", 32'(rd_word[30]), 32'(m_ovf));
        if (q[0].fw != 2) begin
          check("R10 info zero", 32'(rd_word[29:24]), 32'd0);
          check("R4 evid", 32'(rd_word[23:12]), 32'(q[0].ev % 4096));
          if (!q[0].skip)
            check(q[0].early ? "R11 bx" : "R2 bx", 32'(rd_word[11:0]), 32'(q[0].bx));
        end
      end
    end
  endtask

  task automatic tick(bit acc, bit rd, logic [63:0] bf, logic [63:0] ff);
    bit rfire, astore;
    int w;
    evt_t e;
    compare();
    l0_acc = acc; rd_en = rd; buf_flip = bf; fifo_flip = ff; tdc_in = tdc_of(cyc);
    @(posedge clk);
    rfire = rd && q.size() > 0;
    astore = acc && q.size() < DEP;
    w = (cyc >= LAT) ? h_w[cyc-LAT] : 0;
    tried_empty = rd && q.size() == 0;
    m_sec = (astore && w == 1) || (rfire && q[0].fw == 1);
    sec_buf = astore && w == 1;
    if ((astore && w == 2) || (rfire && q[0].fw == 2)) m_ded = 1;
    if (acc && !astore) m_ovf = 1;
    if (rfire) begin
      if (m_phase) void'(q.pop_front());
      m_phase = !m_phase;
    end
    if (astore) begin
      e.early = cyc < LAT;
      e.tdc = e.early ? 32'd0 : h_tdc[cyc-LAT];
      e.bx = e.early ? 0 : (cyc - LAT) % WRAP;
      e.ev = evn; e.fw = $countones(ff); e.skip = w == 2;
      q.push_back(e);
    end
    if (acc) evn++;
    h_tdc.push_back(tdc_of(cyc));
    h_w.push_back($countones(bf));
    cyc++;
    @(negedge clk);
  endtask

  function automatic bit acc_at(int c);
    return c == 5 || c == 40 || c == 170 || c == 200 || c == 201 || c == 230 ||
           (c >= 300 && c < 320) || c == 700 || c == 760 ||
           c == WRAP + LAT - 2 || c == WRAP + LAT - 1 || c == WRAP + LAT ||
           c == 4000 || c == 4050;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    miss++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 rd_info", 32'(rd_info), 0);
    check("R1 flags", {29'd0, sec_fix, ded_err, ovf_err}, 0);
    rst_n = 1'b1;
    for (int c = 0; c < 4300; c++) begin
      logic [63:0] bf, ff;
      bf = '0; ff = '0;
      if (c == 540) bf = 64'd1 << 7;
      if (c == 3840) bf = (64'd1 << 3) | (64'd1 << 20);
      if (c == 760) ff = 64'd1 << 40;
      if (c == 4050) ff = (64'd1 << 2) | (64'd1 << 9);
      tick(acc_at(c), !(c >= 300 && c < 360) && c != 201, bf, ff);
    end
    check("R7 drops counted", 32'(m_ovf), 1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule